// File: doc/BRIEF.md
# Up-Down Counter with Conflict Hold

This block is a small synchronous binary counter with two independent direction requests. A request to count up advances the value by one on each rising clock edge, and a request to count down retreats it by one. When the two requests arrive together they cancel, and the count stays where it is. When neither request is present the count also stays put. Neither direction has priority over the other.

Each stage of the counter flips when every lower stage is all ones while counting up, or all zeros while counting down. The value wraps at both ends of its range. A synchronous active-high reset clears the count, and it overrides both requests. The count leaves the block straight from its register.

Top module: `updown_hold_counter`

## Requirements
- R1: On a rising clock edge with `rst` high the count becomes 0, whatever `up` and `down` hold.
- R2: With `up`=1 and `down`=0, each rising edge sets the count to the previous count plus one.
- R3: With `down`=1 and `up`=0, each rising edge sets the count to the previous count minus one.
- R4: With `up`=1 and `down`=1 together, the count keeps its present value on every edge.
- R5: With `up`=0 and `down`=0, the count keeps its present value on every edge.
- R6: Counting up from the all-ones value (15 for the default width of 4) gives 0.
- R7: Counting down from 0 gives the all-ones value (15 for the default width of 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| up | input | 1 | Request to increment |
| down | input | 1 | Request to decrement |
| count | output | WIDTH (4) | Registered count value |

## Verification
Every stage of the counter is visible on `count`. A wrong toggle condition in any stage therefore shows up on the first edge at which that stage should or should not have flipped. A carry chain that is cut at stage k only shows up once the lower k bits are all ones while counting up, or all zeros while counting down. For that reason the bench walks a full cycle in each direction and also exercises both wrap points. A decode that lets one direction win the conflict changes `count` on the very first edge that sees both requests, so the conflict case is held for several edges from different starting values.

// File: rtl/updown_pkg.sv
package updown_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_t;
endpackage

// File: rtl/dir_decode.sv
module dir_decode
  import updown_pkg::*;
(
  input  logic  req_up,
  input  logic  req_dn,
  output step_t step
);
  always_comb begin
    unique case ({req_up, req_dn})
      2'b10:   step = STEP_INC;
      2'b01:   step = STEP_DEC;
      default: step = STEP_HOLD; // conflict or idle both hold
    endcase
  end
endmodule

// File: rtl/toggle_chain.sv
module toggle_chain
  import updown_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  step_t             step,
  input  logic [WIDTH-1:0]  cur,
  output logic [WIDTH-1:0]  flip
);
  logic [WIDTH:0] all_ones;
  logic [WIDTH:0] all_zeros;

  assign all_ones[0]  = 1'b1;
  assign all_zeros[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign all_ones[i+1]  = all_ones[i]  &  cur[i];
    assign all_zeros[i+1] = all_zeros[i] & ~cur[i];
    always_comb begin
      unique case (step)
        STEP_INC: flip[i] = all_ones[i];
        STEP_DEC: flip[i] = all_zeros[i];
        default:  flip[i] = 1'b0;
      endcase
    end
  end

  logic unused_top;
  assign unused_top = all_ones[WIDTH] ^ all_zeros[WIDTH];
endmodule

// File: rtl/count_reg.sv
module count_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] flip,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q ^ flip;
  end

  // R1: reset clears the register on the next edge
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> q == '0)
    else $error("reset did not clear count");
endmodule

// File: rtl/updown_hold_counter.sv
module updown_hold_counter
  import updown_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up,
  input  logic             down,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

  step_t            step;
  logic [WIDTH-1:0] flip;

  dir_decode u_dec (
    .req_up (up),
    .req_dn (down),
    .step   (step)
  );

  toggle_chain #(.WIDTH(WIDTH)) u_chain (
    .step (step),
    .cur  (count),
    .flip (flip)
  );

  count_reg #(.WIDTH(WIDTH)) u_reg (
    .clk  (clk),
    .rst  (rst),
    .flip (flip),
    .q    (count)
  );

  p_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (up && !down) |=> count == WIDTH'($past(count) + 1'b1))
    else $error("increment wrong");

  p_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (down && !up) |=> count == WIDTH'($past(count) - 1'b1))
    else $error("decrement wrong");

  p_conflict_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (up && down) |=> $stable(count))
    else $error("conflict did not hold");

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!up && !down) |=> $stable(count))
    else $error("idle did not hold");

  p_wrap_up_r6: assert property (@(posedge clk) disable iff (rst)
    (up && !down && count == TOP_VAL) |=> count == '0)
    else $error("upward wrap wrong");

  p_wrap_dn_r7: assert property (@(posedge clk) disable iff (rst)
    (down && !up && count == '0) |=> count == TOP_VAL)
    else $error("downward wrap wrong");
endmodule

// File: tb/sim_updown_hold_counter.sv
module sim_updown_hold_counter;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         up = 1'b0;
  logic         down = 1'b0;
  logic [W-1:0] count;
  int           n_run = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  updown_hold_counter #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .up(up), .down(down), .count(count)
  );

  // Vector: {rst, up, down, expected[3:0]}
  localparam int NV = 18;
  localparam logic [6:0] VEC [NV] = '{
    7'b1_0_0_0000, // R1
    7'b0_1_0_0001, // R2
    7'b0_1_0_0010,
    7'b0_1_0_0011,
    7'b0_1_1_0011, // R4
    7'b0_0_0_0011, // R5
    7'b0_0_1_0010, // R3
    7'b0_0_1_0001,
    7'b0_0_1_0000,
    7'b0_0_1_1111, // R7
    7'b0_1_0_0000, // R6
    7'b0_1_1_0000, // R4 at zero
    7'b0_0_1_1111, // R7
    7'b0_1_1_1111, // R4 at top
    7'b0_0_1_1110,
    7'b0_1_0_1111,
    7'b0_1_0_0000, // R6
    7'b1_1_1_0000  // R1 with both requests
  };

  function automatic string req_of(input logic r, input logic u, input logic d,
                                   input logic [W-1:0] e);
    if (r)           return "R1";
    if (u && d)      return "R4";
    if (!u && !d)    return "R5";
    if (u)           return (e == '0) ? "R6" : "R2";
    return (e == '1) ? "R7" : "R3";
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    n_run++;
    if (count !== exp) begin
      n_fail++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
    end
  endtask

  // One edge with given inputs; sample at the following falling edge.
  task automatic step(input logic r, input logic u, input logic d);
    rst = r; up = u; down = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] model;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4]);
      check(req_of(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:0]), VEC[i][3:0]);
    end

    // Full upward cycle from 0, checking carry into every stage (R2, R6)
    step(1'b1, 1'b0, 1'b0);
    model = '0;
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1'b1, 1'b0);
      model = model + 1'b1;
      check(model == '0 ? "R6" : "R2", model);
    end

    // Full downward cycle, checking borrow into every stage (R3, R7)
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1'b0, 1'b1);
      model = model - 1'b1;
      check(model == '1 ? "R7" : "R3", model);
    end

    // Conflict held over many edges from mid value 1000 (R4)
    step(1'b0, 1'b0, 1'b1); // 0 -> 15
    for (int i = 0; i < 7; i++) step(1'b0, 1'b0, 1'b1); // 15 -> 8
    check("R3", 4'd8);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b1, 1'b1);
      check("R4", 4'd8);
    end
    // Idle held over many edges (R5)
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b0, 1'b0);
      check("R5", 4'd8);
    end
    // Reset with up request clears from nonzero (R1)
    step(1'b1, 1'b1, 1'b0);
    check("R1", 4'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule